// File: doc/BRIEF.md
# HDMI Data Island Period Sequencer

This block produces the stream of 32-bit lane words for one horizontal blanking interval that carries one or more HDMI data packets. It feeds a TMDS lane encoder that has a raw-symbol bypass. Every word it emits already holds the final 10-bit symbol for each of the three lanes, and bit 0 is set so that the encoder passes the symbols through without coding them. After a start pulse it walks through these periods in order:

1. a control period with the sync levels
2. the data-island preamble
3. a leading data guard band
4. the TERC4-coded island
5. a trailing data guard band
6. a second control period
7. the video preamble
8. the video guard band

It then raises a one-cycle video-start flag and goes idle.

Words leave on a valid/ready stream. A word is transferred, and the sequence moves on by one pixel, only in a cycle where `out_valid` and `out_ready` are both high. Outside the island, a word that is offered stays stable until it is taken. Inside the island, the per-lane packet bits come in on a second valid/ready stream that is coupled directly to the output. `pkt_ready` is high only in island cycles where the consumer is ready. `out_valid` follows `pkt_valid` there. One set of packet bits is consumed for each island word transferred, so stalls on either side hold the packet data in place.

Top module: `hdmi_isl_seq`

## Requirements
- R1: A `start` pulse in idle begins a new sequence, with `lead_len`, `gap_len` and `pkt_num` sampled in that cycle. A `start` while a sequence is running is ignored, and the running sequence continues word for word.
- R2: The periods follow the order given above, each with a fixed number of words:
  - lead control: `lead_len` words, where 0 counts as 1
  - data preamble: 8 words
  - data guard band: 2 words
  - island: 32 × `pkt_num` words, where 0 counts as 1
  - data guard band: 2 words
  - gap control: `gap_len` words, where 0 counts as 1
  - video preamble: 8 words
  - video guard band: 2 words
- R3: The word layout is lane 2 in [31:22], lane 1 in [21:12] and lane 0 in [11:2], with bit 1 = 0 and bit 0 = 1.
- R4: Control symbols are indexed by the 2-bit value {c1,c0}: 00→1101010100, 01→0010101011, 10→0101010100, 11→1010101011. In both control periods and both preambles, lane 0 sends the control symbol of {vsync,hsync}. Lanes 1 and 2 send the following indices:
  - control periods: 00 on both lanes
  - data preamble: 01 on both lanes
  - video preamble: 01 on lane 1 and 00 on lane 2
- R5: In both data guard bands, lanes 1 and 2 send 0100110011, and lane 0 sends TERC4({1,1,vsync,hsync}).
- R6: In the island, lane 1 sends TERC4(`pkt_l1_nib`), lane 2 sends TERC4(`pkt_l2_nib`), and lane 0 sends TERC4({`pkt_l0_bits`,vsync,hsync}). TERC4 maps nibbles 0 to 15 to the following codes, in that order: 1010011100, 1001100011, 1011100100, 1011100010, 0101110001, 0100011110, 0110001110, 0100111100, 1011001100, 0100111001, 0110011100, 1011000110, 1010001110, 1001110001, 0101100011, 1011000011.
- R7: In the video guard band, lanes 0 and 2 send 1011001100 and lane 1 sends 0100110011.
- R8: `out_valid` is low in idle. The sequence advances only on a transfer (`out_valid` and `out_ready` both high). Outside the island, `out_valid` stays high until the word is taken.
- R9: In the island, `out_valid` equals `pkt_valid` and `pkt_ready` equals `out_ready`. Outside the island, `pkt_ready` is low.
- R10: `vid_start` is high for exactly one cycle: the cycle after the last video-guard-band word is transferred. In that cycle the block is already idle.
- R11: After reset the block is idle, with `out_valid`, `pkt_ready` and `vid_start` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a blanking sequence (used only in idle) |
| hsync | input | 1 | Horizontal sync level, carried on lane 0 |
| vsync | input | 1 | Vertical sync level, carried on lane 0 |
| lead_len | input | LEN_W | Words in the lead control period |
| gap_len | input | LEN_W | Words in the gap control period |
| pkt_num | input | PKT_W | Packets in the island (32 words each) |
| pkt_valid | input | 1 | Packet bits are present |
| pkt_ready | output | 1 | Packet bits are consumed this cycle |
| pkt_l0_bits | input | 2 | Packet bits for the upper half of the lane 0 nibble |
| pkt_l1_nib | input | 4 | Packet nibble for lane 1 |
| pkt_l2_nib | input | 4 | Packet nibble for lane 2 |
| out_valid | output | 1 | Lane word is offered |
| out_ready | input | 1 | Consumer takes the word |
| out_word | output | 32 | Raw lane word |
| vid_start | output | 1 | One-cycle hand-off to active video |

## Verification
The bench targets the following corner cases:
- **Zero lengths.** A design that loads a count of zero would underflow its counter and emit hundreds of control words instead of one.
- **Stalls on either stream.** If stalls were not handled, an island word would repeat or skip a nibble, or a guard band would be cut to one word.
- **Sync changing every pixel.** A lane 0 that latches sync once per period would show stale control or TERC4 codes.
- **`start` asserted mid-sequence.** A design that restarts on it would break the period order or the total word count.
- **The `vid_start` edge.** A pulse that comes one cycle early or late, or lasts two cycles, marks the hand-off at the wrong pixel.

// File: rtl/hdmi_isl_pkg.sv
package hdmi_isl_pkg;

  typedef enum logic [3:0] {
    P_IDLE,
    P_CTL_LEAD,
    P_DPRE,
    P_DGB_LEAD,
    P_ISL,
    P_DGB_TAIL,
    P_CTL_GAP,
    P_VPRE,
    P_VGB
  } period_t;

  localparam int SYM_W   = 10;
  localparam int LANES   = 3;
  localparam int PRE_LEN = 8;
  localparam int GB_LEN  = 2;
  localparam int GRP_SH  = 5;  // 32 island words per packet

  localparam logic [SYM_W-1:0] GB_DATA_SYM = 10'b0100110011;
  localparam logic [SYM_W-1:0] GB_VID_SYM  = 10'b1011001100;

  function automatic logic [SYM_W-1:0] terc4(input logic [3:0] n);
    logic [SYM_W-1:0] s;
    case (n)
      4'h0: s = 10'b1010011100;
      4'h1: s = 10'b1001100011;
      4'h2: s = 10'b1011100100;
      4'h3: s = 10'b1011100010;
      4'h4: s = 10'b0101110001;
      4'h5: s = 10'b0100011110;
      4'h6: s = 10'b0110001110;
      4'h7: s = 10'b0100111100;
      4'h8: s = 10'b1011001100;
      4'h9: s = 10'b0100111001;
      4'hA: s = 10'b0110011100;
      4'hB: s = 10'b1011000110;
      4'hC: s = 10'b1010001110;
      4'hD: s = 10'b1001110001;
      4'hE: s = 10'b0101100011;
      default: s = 10'b1011000011;
    endcase
    return s;
  endfunction

  function automatic logic [SYM_W-1:0] ctl_sym(input logic [1:0] c);
    logic [SYM_W-1:0] s;
    case (c)
      2'b00: s = 10'b1101010100;
      2'b01: s = 10'b0010101011;
      2'b10: s = 10'b0101010100;
      default: s = 10'b1010101011;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/isl_period_fsm.sv
module isl_period_fsm
  import hdmi_isl_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int PKT_W = 3,
  parameter int CW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             fire,
  input  logic [LEN_W-1:0] lead_len,
  input  logic [LEN_W-1:0] gap_len,
  input  logic [PKT_W-1:0] pkt_num,
  output period_t          period,
  output logic             vid_start
);

  logic [CW-1:0]    cnt;
  logic [LEN_W-1:0] gap_q;
  logic [PKT_W-1:0] pkt_q;
  period_t          nxt;
  logic [CW-1:0]    nxt_last;
  logic [CW-1:0]    lead_last;
  logic [PKT_W-1:0] pkt_eff;

  function automatic logic [CW-1:0] len_last(input logic [LEN_W-1:0] l);
    return (l == '0) ? '0 : CW'(l) - CW'(1);
  endfunction

  assign lead_last = len_last(lead_len);
  assign pkt_eff   = (pkt_q == '0) ? PKT_W'(1) : pkt_q;

  always_comb begin
    nxt      = P_IDLE;
    nxt_last = '0;
    case (period)
      P_CTL_LEAD: begin nxt = P_DPRE;     nxt_last = CW'(PRE_LEN - 1); end
      P_DPRE:     begin nxt = P_DGB_LEAD; nxt_last = CW'(GB_LEN - 1);  end
      P_DGB_LEAD: begin
        nxt      = P_ISL;
        nxt_last = CW'({pkt_eff, {GRP_SH{1'b0}}}) - CW'(1);
      end
      P_ISL:      begin nxt = P_DGB_TAIL; nxt_last = CW'(GB_LEN - 1);  end
      P_DGB_TAIL: begin nxt = P_CTL_GAP;  nxt_last = len_last(gap_q);  end
      P_CTL_GAP:  begin nxt = P_VPRE;     nxt_last = CW'(PRE_LEN - 1); end
      P_VPRE:     begin nxt = P_VGB;      nxt_last = CW'(GB_LEN - 1);  end
      default:    begin nxt = P_IDLE;     nxt_last = '0;               end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period    <= P_IDLE;
      cnt       <= '0;
      gap_q     <= '0;
      pkt_q     <= '0;
      vid_start <= 1'b0;
    end else begin
      vid_start <= 1'b0;
      if (period == P_IDLE) begin
        if (start) begin
          period <= P_CTL_LEAD;
          cnt    <= lead_last;
          gap_q  <= gap_len;
          pkt_q  <= pkt_num;
        end
      end else if (fire) begin
        if (cnt == '0) begin
          period <= nxt;
          cnt    <= nxt_last;
          if (period == P_VGB) vid_start <= 1'b1;
        end else begin
          cnt <= cnt - CW'(1);
        end
      end
    end
  end

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (period != P_IDLE && !fire) |=> (period == $past(period) && cnt == $past(cnt))); // R8
  AST_GB_TWO_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
    ((period == P_DGB_LEAD || period == P_DGB_TAIL || period == P_VGB) && $past(rst_n)
     && period != $past(period)) |-> cnt == CW'(1)); // R2
  AST_ISL_AFTER_GB: assert property (@(posedge clk) disable iff (!rst_n)
    (period == P_ISL && $past(rst_n) && $past(period) != P_ISL) |-> $past(period) == P_DGB_LEAD); // R2
  AST_VSTART_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    vid_start |-> ($past(period) == P_VGB && period == P_IDLE)); // R10
  AST_VSTART_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    vid_start |=> !vid_start); // R10

endmodule

// File: rtl/isl_lane_mux.sv
module isl_lane_mux
  import hdmi_isl_pkg::*;
(
  input  period_t      period,
  input  logic         hsync,
  input  logic         vsync,
  input  logic [1:0]   l0_bits,
  input  logic [3:0]   l1_nib,
  input  logic [3:0]   l2_nib,
  output logic [31:0]  word
);

  logic [3:0]       nib [LANES];
  logic [SYM_W-1:0] sym [LANES];

  always_comb begin
    nib[0] = {l0_bits, vsync, hsync};
    nib[1] = l1_nib;
    nib[2] = l2_nib;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [1:0] cbits;
    always_comb begin
      if (g == 0) cbits = {vsync, hsync};
      else if (period == P_DPRE) cbits = 2'b01;
      else if (period == P_VPRE && g == 1) cbits = 2'b01;
      else cbits = 2'b00;
    end

    always_comb begin
      case (period)
        P_DGB_LEAD, P_DGB_TAIL:
          sym[g] = (g == 0) ? terc4({2'b11, vsync, hsync}) : GB_DATA_SYM;
        P_ISL:
          sym[g] = terc4(nib[g]);
        P_VGB:
          sym[g] = (g == 1) ? GB_DATA_SYM : GB_VID_SYM;
        default:
          sym[g] = ctl_sym(cbits);
      endcase
    end
  end

  assign word = {sym[2], sym[1], sym[0], 2'b01};

endmodule

// File: rtl/hdmi_isl_seq.sv
module hdmi_isl_seq
  import hdmi_isl_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int PKT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             hsync,
  input  logic             vsync,
  input  logic [LEN_W-1:0] lead_len,
  input  logic [LEN_W-1:0] gap_len,
  input  logic [PKT_W-1:0] pkt_num,
  input  logic             pkt_valid,
  output logic             pkt_ready,
  input  logic [1:0]       pkt_l0_bits,
  input  logic [3:0]       pkt_l1_nib,
  input  logic [3:0]       pkt_l2_nib,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_word,
  output logic             vid_start
);

  localparam int ISL_W = PKT_W + GRP_SH;
  localparam int CW    = (LEN_W > ISL_W) ? LEN_W : ISL_W;

  period_t period;
  logic    fire;

  assign out_valid = (period != P_IDLE) && (period != P_ISL || pkt_valid);
  assign pkt_ready = (period == P_ISL) && out_ready;
  assign fire      = out_valid && out_ready;

  isl_period_fsm #(.LEN_W(LEN_W), .PKT_W(PKT_W), .CW(CW)) fsm_i (
    .clk(clk), .rst_n(rst_n), .start(start), .fire(fire),
    .lead_len(lead_len), .gap_len(gap_len), .pkt_num(pkt_num),
    .period(period), .vid_start(vid_start)
  );

  isl_lane_mux mux_i (
    .period(period), .hsync(hsync), .vsync(vsync),
    .l0_bits(pkt_l0_bits), .l1_nib(pkt_l1_nib), .l2_nib(pkt_l2_nib),
    .word(out_word)
  );

  AST_IDLE_AT_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    vid_start |-> (!out_valid && !pkt_ready)); // R10
  AST_PKT_ONLY_ISLAND: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_ready) |-> (out_valid && out_ready)); // R9
  AST_RESET_QUIET: assert property (@(posedge clk)
    !$past(rst_n) |-> (!out_valid && !vid_start)); // R11

endmodule

// File: tb/hdmi_isl_seq_tb.sv
`timescale 1ns/1ps
module hdmi_isl_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, hsync = 1'b0, vsync = 1'b0;
  logic [7:0]  lead_len = '0, gap_len = '0;
  logic [2:0]  pkt_num = '0;
  logic        pkt_valid = 1'b0, out_ready = 1'b0;
  logic [1:0]  pkt_l0_bits = '0;
  logic [3:0]  pkt_l1_nib = '0, pkt_l2_nib = '0;
  logic        pkt_ready, out_valid, vid_start;
  logic [31:0] out_word;

  always #2 clk = ~clk;

  hdmi_isl_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .hsync(hsync), .vsync(vsync),
    .lead_len(lead_len), .gap_len(gap_len), .pkt_num(pkt_num),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_l0_bits(pkt_l0_bits),
    .pkt_l1_nib(pkt_l1_nib), .pkt_l2_nib(pkt_l2_nib),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .vid_start(vid_start)
  );

  int compared = 0, mismatched = 0, cyc = 0;
  int q[$];
  int ptr = 0, words_run = 0, words_exp = 0;
  bit exp_vs = 0, start_drv = 0;
  int rdy_pct = 100, val_pct = 100;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      mismatched++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [9:0] t4(input logic [3:0] n);
    logic [9:0] tbl [16] = '{10'b1010011100, 10'b1001100011, 10'b1011100100, 10'b1011100010,
                             10'b0101110001, 10'b0100011110, 10'b0110001110, 10'b0100111100,
                             10'b1011001100, 10'b0100111001, 10'b0110011100, 10'b1011000110,
                             10'b1010001110, 10'b1001110001, 10'b0101100011, 10'b1011000011};
    return tbl[n];
  endfunction

  function automatic logic [9:0] cs(input logic [1:0] c);
    logic [9:0] tbl [4] = '{10'b1101010100, 10'b0010101011, 10'b0101010100, 10'b1010101011};
    return tbl[c];
  endfunction

  function automatic logic [3:0] nibf(input int p, input int l);
    return 4'((p * 7 + l * 5 + 3) ^ (p >> 2));
  endfunction

  // kinds: 0 control, 1 data preamble, 2 data guard, 3 island, 4 video preamble, 5 video guard
  function automatic logic [31:0] exp_word(input int k);
    logic [9:0] l0, l1, l2;
    logic [1:0] sy;
    logic [3:0] n0;
    sy = {vsync, hsync};
    n0 = nibf(ptr, 0);
    l0 = cs(sy); l1 = cs(2'b00); l2 = cs(2'b00);
    case (k)
      1: begin l1 = cs(2'b01); l2 = cs(2'b01); end
      4: begin l1 = cs(2'b01); end
      2: begin l0 = t4({2'b11, sy}); l1 = 10'b0100110011; l2 = 10'b0100110011; end
      3: begin l0 = t4({n0[1:0], sy}); l1 = t4(nibf(ptr, 1)); l2 = t4(nibf(ptr, 2)); end
      5: begin l0 = 10'b1011001100; l1 = 10'b0100110011; l2 = 10'b1011001100; end
      default: ;
    endcase
    return {l2, l1, l0, 2'b01};
  endfunction

  function automatic string req_of(input int k);
    case (k)
      2: return "R3/R5 data guard word";
      3: return "R3/R6 island word";
      5: return "R3/R7 video guard word";
      default: return "R3/R4 control/preamble word";
    endcase
  endfunction

  task automatic push_n(input int k, input int n);
    for (int i = 0; i < n; i++) q.push_back(k);
  endtask

  task automatic build(input int ld, input int gp, input int pk);
    int l1, g1, p1;
    l1 = (ld == 0) ? 1 : ld;
    g1 = (gp == 0) ? 1 : gp;
    p1 = (pk == 0) ? 1 : pk;
    push_n(0, l1); push_n(1, 8); push_n(2, 2); push_n(3, 32 * p1);
    push_n(2, 2); push_n(0, g1); push_n(4, 8); push_n(5, 2);
    words_exp = l1 + g1 + 22 + 32 * p1;
    words_run = 0;
  endtask

  task automatic step();
    logic [3:0] n0;
    bit was_empty, ev;
    int k;
    @(negedge clk);
    out_ready = (($urandom % 100) < rdy_pct);
    pkt_valid = (($urandom % 100) < val_pct);
    hsync = 1'($urandom);
    vsync = 1'($urandom);
    n0 = nibf(ptr, 0);
    pkt_l0_bits = n0[1:0];
    pkt_l1_nib = nibf(ptr, 1);
    pkt_l2_nib = nibf(ptr, 2);
    start = start_drv;
    #1;
    was_empty = (q.size() == 0);
    k = was_empty ? -1 : q[0];
    ev = !was_empty && (k != 3 || pkt_valid);
    chk(out_valid === ev, "R8/R9 out_valid", 32'(out_valid), 32'(ev));
    chk(vid_start === exp_vs, "R10 vid_start", 32'(vid_start), 32'(exp_vs));
    chk(pkt_ready === (k == 3 && out_ready), "R9 pkt_ready", 32'(pkt_ready), 32'(k == 3 && out_ready));
    if (ev && out_valid) begin
      chk(out_word[1:0] === 2'b01, "R3 raw flag bits", 32'(out_word[1:0]), 32'd1);
      chk(out_word === exp_word(k), req_of(k), out_word, exp_word(k));
    end
    exp_vs = 0;
    if (ev && out_ready) begin
      void'(q.pop_front());
      words_run++;
      if (k == 3) ptr++;
      if (q.size() == 0) exp_vs = 1;
    end
    if (start && was_empty) build(int'(lead_len), int'(gap_len), int'(pkt_num));
  endtask

  task automatic run_seq(input int ld, input int gp, input int pk,
                         input int rp, input int vp, input bit busy_start);
    int n;
    lead_len = 8'(ld); gap_len = 8'(gp); pkt_num = 3'(pk);
    rdy_pct = rp; val_pct = vp;
    start_drv = 1; step(); start_drv = 0;
    n = 0;
    while (q.size() > 0 || exp_vs) begin
      start_drv = busy_start && (n == 15);
      step();
      start_drv = 0;
      n++;
    end
    chk(words_run == words_exp, "R1/R2 total words in sequence", 32'(words_run), 32'(words_exp));
    for (int i = 0; i < 4; i++) step();  // idle: R8 out_valid must stay low
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid === 1'b0, "R11 reset out_valid", 32'(out_valid), 0);
    chk(vid_start === 1'b0, "R11 reset vid_start", 32'(vid_start), 0);
    chk(pkt_ready === 1'b0, "R11 reset pkt_ready", 32'(pkt_ready), 0);
    rst_n = 1'b1;
    step();
    run_seq(3, 2, 1, 100, 100, 0);   // full rate
    run_seq(0, 0, 0, 100, 100, 0);   // zero lengths count as one
    run_seq(5, 4, 2, 60, 70, 1);     // stalls both sides, start while busy (R1)
    run_seq(1, 1, 1, 30, 100, 0);    // heavy output back-pressure
    run_seq(2, 6, 3, 90, 40, 1);     // sparse packet input
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule